// File: doc/BRIEF.md
# ALU Operand Bypass Selector

This block picks the two operands fed to the ALU of a five-stage in-order pipeline. Each operand has three possible sources:

- the value the register file returned during decode;
- the result waiting in the execute-to-memory pipeline register;
- the result waiting in the memory-to-writeback pipeline register. This is either an ALU result or data loaded from memory.

The block compares each source specifier of the instruction now in execute with the destination specifiers of the two older instructions. A newer result then replaces a stale register-file value without the pipeline having to wait.

The block is purely combinational. It has no clock and no state. Results three instructions back are never bypassed. The register file writes in the first half of a cycle and reads in the second half, so the decode stage already sees those results. Stall generation and the register file itself sit outside this block.

Top module: `alu_bypass_select`

## Requirements
- R1: When no enabled older stage matches an operand's source specifier, that operand's select code is 2'b00 and the operand equals its register-file value.
- R2: When the execute/memory stage has its write enable high, a nonzero destination, and a destination equal to an operand's source, that operand's select code is 2'b10 and the operand equals the execute/memory result.
- R3: When only the memory/writeback stage matches (write enable high, nonzero destination equal to the source), the select code is 2'b01. The operand equals the loaded data when the load flag is 1, and the ALU result when it is 0.
- R4: When both older stages match the same source, the execute/memory stage wins with select code 2'b10.
- R5: A stage whose write enable is 0 never supplies an operand, even when its destination matches.
- R6: A destination of register 0 never supplies an operand, even when the source is also register 0 and the write enable is high.
- R7: The two operands are resolved independently. Each may take a different source, or both may take the same one. The second operand, which carries store data, may take loaded data from the memory/writeback stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | REG_AW | First source specifier of the instruction in execute |
| src_b | input | REG_AW | Second source specifier of the instruction in execute |
| rf_a | input | DATA_W | Register-file value for the first operand |
| rf_b | input | DATA_W | Register-file value for the second operand |
| exm_rd | input | REG_AW | Destination specifier in the execute/memory register |
| exm_wen | input | 1 | Register write enable in the execute/memory register |
| exm_result | input | DATA_W | ALU result in the execute/memory register |
| mwb_rd | input | REG_AW | Destination specifier in the memory/writeback register |
| mwb_wen | input | 1 | Register write enable in the memory/writeback register |
| mwb_is_load | input | 1 | 1 when the memory/writeback instruction is a load |
| mwb_alu_result | input | DATA_W | ALU result in the memory/writeback register |
| mwb_load_data | input | DATA_W | Loaded data in the memory/writeback register |
| op_a | output | DATA_W | Selected first ALU operand |
| op_b | output | DATA_W | Selected second ALU operand / store data |
| sel_a | output | 2 | Select code of the first operand |
| sel_b | output | 2 | Select code of the second operand |

## Verification
The block holds no state, so any fault in the match or priority logic shows up in the same cycle the inputs settle. It appears as a wrong select code, or as an operand that carries the wrong stage's value.

The stimulus therefore sets distinct data values on every source. That way a wrong choice cannot hide behind equal numbers. It then walks through several specifier patterns:

- matches from each stage;
- double matches, to check priority;
- disabled writes;
- register 0.

A sweep over every specifier value exposes a comparator that ignores some bit of the specifier.

// File: rtl/alu_bypass_select.sv
module alu_bypass_select #(
  parameter int REG_AW = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_AW-1:0] src_a,
  input  logic [REG_AW-1:0] src_b,
  input  logic [DATA_W-1:0] rf_a,
  input  logic [DATA_W-1:0] rf_b,
  input  logic [REG_AW-1:0] exm_rd,
  input  logic              exm_wen,
  input  logic [DATA_W-1:0] exm_result,
  input  logic [REG_AW-1:0] mwb_rd,
  input  logic              mwb_wen,
  input  logic              mwb_is_load,
  input  logic [DATA_W-1:0] mwb_alu_result,
  input  logic [DATA_W-1:0] mwb_load_data,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b
);

  localparam int          NUM_OPS = 2;
  localparam logic [1:0]  SEL_RF  = 2'b00;
  localparam logic [1:0]  SEL_WB  = 2'b01;
  localparam logic [1:0]  SEL_EX  = 2'b10;
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic              ex_live, wb_live;
  logic [DATA_W-1:0] wb_value;

  assign ex_live  = exm_wen && (exm_rd != ZERO_REG);
  assign wb_live  = mwb_wen && (mwb_rd != ZERO_REG);
  assign wb_value = mwb_is_load ? mwb_load_data : mwb_alu_result;

  logic [REG_AW-1:0] src [NUM_OPS];
  logic [DATA_W-1:0] rfv [NUM_OPS];
  logic [DATA_W-1:0] opd [NUM_OPS];
  logic [1:0]        sel [NUM_OPS];

  assign src[0] = src_a;
  assign src[1] = src_b;
  assign rfv[0] = rf_a;
  assign rfv[1] = rf_b;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    logic hit_ex, hit_wb;
    assign hit_ex = ex_live && (exm_rd == src[g]);
    assign hit_wb = wb_live && (mwb_rd == src[g]);

    always_comb begin
      if (hit_ex)      sel[g] = SEL_EX;
      else if (hit_wb) sel[g] = SEL_WB;
      else             sel[g] = SEL_RF;
    end

    always_comb begin
      unique case (sel[g])
        SEL_EX:  opd[g] = exm_result;
        SEL_WB:  opd[g] = wb_value;
        default: opd[g] = rfv[g];
      endcase
    end
  end

  assign op_a  = opd[0];
  assign op_b  = opd[1];
  assign sel_a = sel[0];
  assign sel_b = sel[1];

endmodule

// File: rtl/alu_bypass_select_chk.sv
module alu_bypass_select_chk #(
  parameter int REG_AW = 5,
  parameter int DATA_W = 32
) (
  input logic [REG_AW-1:0] src_a,
  input logic [REG_AW-1:0] src_b,
  input logic [DATA_W-1:0] rf_a,
  input logic [DATA_W-1:0] rf_b,
  input logic [REG_AW-1:0] exm_rd,
  input logic              exm_wen,
  input logic [DATA_W-1:0] exm_result,
  input logic [REG_AW-1:0] mwb_rd,
  input logic              mwb_wen,
  input logic              mwb_is_load,
  input logic [DATA_W-1:0] mwb_alu_result,
  input logic [DATA_W-1:0] mwb_load_data,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b
);

  logic [DATA_W-1:0] ld_or_alu;
  assign ld_or_alu = mwb_is_load ? mwb_load_data : mwb_alu_result;

  always_comb begin
    AST_SEL_A_LEGAL: assert (sel_a != 2'b11) else $error("sel_a illegal"); // R1
    AST_SEL_B_LEGAL: assert (sel_b != 2'b11) else $error("sel_b illegal"); // R1
    AST_RF_A_PASS: assert (sel_a != 2'b00 || op_a == rf_a) else $error("op_a not rf"); // R1
    AST_RF_B_PASS: assert (sel_b != 2'b00 || op_b == rf_b) else $error("op_b not rf"); // R1
    AST_EX_A_JUST: assert (sel_a != 2'b10 || (exm_wen && exm_rd == src_a && op_a == exm_result)) else $error("ex sel a"); // R2
    AST_EX_B_JUST: assert (sel_b != 2'b10 || (exm_wen && exm_rd == src_b && op_b == exm_result)) else $error("ex sel b"); // R2
    AST_WB_A_JUST: assert (sel_a != 2'b01 || (mwb_wen && mwb_rd == src_a && op_a == ld_or_alu)) else $error("wb sel a"); // R3
    AST_WB_B_JUST: assert (sel_b != 2'b01 || (mwb_wen && mwb_rd == src_b && op_b == ld_or_alu)) else $error("wb sel b"); // R3
    AST_EX_A_PRIO: assert (!(exm_wen && exm_rd == src_a && src_a != '0) || sel_a == 2'b10) else $error("prio a"); // R4
    AST_EX_B_PRIO: assert (!(exm_wen && exm_rd == src_b && src_b != '0) || sel_b == 2'b10) else $error("prio b"); // R4
    AST_ZERO_A_RF: assert (src_a != '0 || sel_a == 2'b00) else $error("zero a"); // R6
    AST_ZERO_B_RF: assert (src_b != '0 || sel_b == 2'b00) else $error("zero b"); // R6
  end

endmodule

bind alu_bypass_select alu_bypass_select_chk #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_chk (
  .src_a(src_a), .src_b(src_b), .rf_a(rf_a), .rf_b(rf_b),
  .exm_rd(exm_rd), .exm_wen(exm_wen), .exm_result(exm_result),
  .mwb_rd(mwb_rd), .mwb_wen(mwb_wen), .mwb_is_load(mwb_is_load),
  .mwb_alu_result(mwb_alu_result), .mwb_load_data(mwb_load_data),
  .op_a(op_a), .op_b(op_b), .sel_a(sel_a), .sel_b(sel_b)
);

// File: tb/test_alu_bypass_select.sv
module test_alu_bypass_select;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam logic [DW-1:0] RFA = 32'hA1A1_0001;
  localparam logic [DW-1:0] RFB = 32'hB2B2_0002;
  localparam logic [DW-1:0] EXV = 32'hE3E3_0003;
  localparam logic [DW-1:0] ALV = 32'hC4C4_0004;
  localparam logic [DW-1:0] LDV = 32'hD5D5_0005;

  typedef struct packed {
    logic [AW-1:0] s1, s2, ed;
    logic          ew;
    logic [AW-1:0] md;
    logic          mw, ml;
    logic [1:0]    ea, eb;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{5'd3,  5'd4,  5'd7,  1'b1, 5'd9,  1'b1, 1'b0, 2'b00, 2'b00, 4'd1}, // R1
    '{5'd3,  5'd4,  5'd3,  1'b1, 5'd9,  1'b1, 1'b0, 2'b10, 2'b00, 4'd2}, // R2
    '{5'd3,  5'd4,  5'd4,  1'b1, 5'd9,  1'b1, 1'b0, 2'b00, 2'b10, 4'd2}, // R2
    '{5'd5,  5'd6,  5'd1,  1'b1, 5'd5,  1'b1, 1'b0, 2'b01, 2'b00, 4'd3}, // R3 alu
    '{5'd5,  5'd6,  5'd1,  1'b1, 5'd5,  1'b1, 1'b1, 2'b01, 2'b00, 4'd3}, // R3 load
    '{5'd8,  5'd8,  5'd8,  1'b1, 5'd8,  1'b1, 1'b1, 2'b10, 2'b10, 4'd4}, // R4
    '{5'd8,  5'd2,  5'd8,  1'b0, 5'd8,  1'b1, 1'b0, 2'b01, 2'b00, 4'd5}, // R5
    '{5'd8,  5'd2,  5'd9,  1'b1, 5'd8,  1'b0, 1'b0, 2'b00, 2'b00, 4'd5}, // R5
    '{5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 1'b1, 2'b00, 2'b00, 4'd6}, // R6
    '{5'd0,  5'd7,  5'd0,  1'b1, 5'd7,  1'b1, 1'b1, 2'b00, 2'b01, 4'd7}, // R7 store data from load
    '{5'd12, 5'd13, 5'd13, 1'b1, 5'd12, 1'b1, 1'b0, 2'b01, 2'b10, 4'd7}, // R7
    '{5'd31, 5'd31, 5'd31, 1'b0, 5'd31, 1'b1, 1'b0, 2'b01, 2'b01, 4'd7}  // R7
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] src_a, src_b, exm_rd, mwb_rd;
  logic [DW-1:0] rf_a, rf_b, exm_result, mwb_alu_result, mwb_load_data, op_a, op_b;
  logic          exm_wen, mwb_wen, mwb_is_load;
  logic [1:0]    sel_a, sel_b;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  alu_bypass_select #(.REG_AW(AW), .DATA_W(DW)) i_alu_bypass_select (
    .src_a(src_a), .src_b(src_b), .rf_a(rf_a), .rf_b(rf_b),
    .exm_rd(exm_rd), .exm_wen(exm_wen), .exm_result(exm_result),
    .mwb_rd(mwb_rd), .mwb_wen(mwb_wen), .mwb_is_load(mwb_is_load),
    .mwb_alu_result(mwb_alu_result), .mwb_load_data(mwb_load_data),
    .op_a(op_a), .op_b(op_b), .sel_a(sel_a), .sel_b(sel_b)
  );

  function automatic logic [DW-1:0] want_op(logic [1:0] s, logic [DW-1:0] rf, logic ld);
    case (s)
      2'b10:   return EXV;
      2'b01:   return ld ? LDV : ALV;
      default: return rf;
    endcase
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    @(posedge clk);
    src_a = v.s1; src_b = v.s2; exm_rd = v.ed; exm_wen = v.ew;
    mwb_rd = v.md; mwb_wen = v.mw; mwb_is_load = v.ml;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    vec_t v;
    rf_a = RFA; rf_b = RFB; exm_result = EXV; mwb_alu_result = ALV; mwb_load_data = LDV;
    src_a = '0; src_b = '0; exm_rd = '0; mwb_rd = '0;
    exm_wen = 1'b0; mwb_wen = 1'b0; mwb_is_load = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 quiescent sel_a", {30'd0, sel_a}, 32'd0);
    chk("R1 quiescent op_b", op_b, RFB);

    for (int i = 0; i < NV; i++) begin
      v = TBL[i];
      drive(v);
      chk($sformatf("R%0d row%0d sel_a", v.req, i), {30'd0, sel_a}, {30'd0, v.ea});
      chk($sformatf("R%0d row%0d sel_b", v.req, i), {30'd0, sel_b}, {30'd0, v.eb});
      chk($sformatf("R%0d row%0d op_a", v.req, i), op_a, want_op(v.ea, RFA, v.ml));
      chk($sformatf("R%0d row%0d op_b", v.req, i), op_b, want_op(v.eb, RFB, v.ml));
    end

    // R2 / R6 sweep over every specifier: only register 0 is excluded
    for (int r = 0; r < 32; r++) begin
      v = '{5'(r), 5'(31 - r), 5'(r), 1'b1, 5'(31 - r), 1'b1, 1'b0, 2'b00, 2'b00, 4'd2};
      drive(v);
      chk($sformatf("R2 sweep r=%0d sel_a", r), {30'd0, sel_a}, (r == 0) ? 32'd0 : 32'd2);
      chk($sformatf("R3 sweep r=%0d op_b", r), op_b, (r == 31) ? RFB : ALV);
    end

    // R1: register-file data passes straight through when nothing matches
    v = '{5'd10, 5'd11, 5'd20, 1'b1, 5'd21, 1'b1, 1'b0, 2'b00, 2'b00, 4'd1};
    drive(v);
    rf_a = 32'h1234_5678;
    @(negedge clk);
    chk("R1 rf change op_a", op_a, 32'h1234_5678);
    rf_a = RFA;

    // R3: load flag toggled with match held picks the other value
    v = '{5'd10, 5'd11, 5'd20, 1'b0, 5'd10, 1'b1, 1'b1, 2'b01, 2'b00, 4'd3};
    drive(v);
    chk("R3 load op_a", op_a, LDV);
    mwb_is_load = 1'b0;
    @(negedge clk);
    chk("R3 alu op_a", op_a, ALV);

    done = 1'b1;
    finish_run();
  end
endmodule